// File: doc/BRIEF.md
# Poll-Read DMA Launcher

This block is a slave on the host bus. It starts fetches of command packets for a graphics accelerator. The host does not write a start register. It reads one word inside a poll window, and the offset of that read carries the buffer address. The accelerator sees system memory through a remapped view. In that view, every address bit from 15 upward sits three places higher than in the system address. The block undoes that remap. It turns the poll offset back into a system buffer address on the 23-bit, word-aligned host map. It then presents that address, with a transfer length, on a request/acknowledge port to the DMA engine.

The same read returns a status word. The value 0 means the fetch was taken. The value 1 means it was refused. A read is refused when the engine is still working on an earlier packet. It is also refused when the packet would run past a 32 KB window boundary or is longer than 4 KB. Either length fault sets a sticky error flag. A refused read launches nothing.

Top module: `pollDmaLauncher`

## Requirements
- R1: After reset `dmaReq`, `rdValid` and `errFlag` are 0 and the engine is idle. The first legal poll read is accepted.
- R2: A poll read sampled on one clock edge gives `rdValid` high for exactly the following cycle. `rdData` is then 0 when the fetch is accepted and 1 when it is refused. All other bits of `rdData` are 0.
- R3: The accepted buffer address is built from the poll offset as follows. Address bits 14:11 take offset bits 5:2. Address bits 22:15 take offset bits 16:9. Address bits 10:0 are 0.
- R4: Offset bits 1:0, 8:6 and 19:17 have no effect on the address or on the status.
- R5: `dmaReq` stays high from acceptance until `dmaAck` is sampled, and then drops. While it is high, `dmaAddr` and `dmaLen` do not change.
- R6: From acceptance until `dmaDone` is sampled in the running phase, every poll read returns 1 and launches no new request.
- R7: If `dmaDone` and a legal poll read arrive in the same cycle, the completion is taken first. The read returns 0 and raises a new request.
- R8: A read whose address bits 14:0 plus `pollLen` exceed 32768 is refused with status 1 and sets `errFlag`. A packet that ends exactly on the boundary is accepted.
- R9: A read with `pollLen` above 4096 is refused with status 1 and sets `errFlag`.
- R10: `errFlag` stays set until reset and does not block later legal reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pollRd | input | 1 | One-cycle read strobe into the poll window |
| pollOff | input | 20 | Byte offset of the read inside the poll window |
| pollLen | input | 13 | Packet length in bytes for this read |
| rdValid | output | 1 | Read data valid, one cycle after `pollRd` |
| rdData | output | 32 | Status word: 0 = accepted, 1 = refused |
| dmaReq | output | 1 | Fetch request to the DMA engine |
| dmaAddr | output | 23 | System buffer address of the packet |
| dmaLen | output | 13 | Packet length in bytes |
| dmaAck | input | 1 | Engine has taken the request |
| dmaDone | input | 1 | Engine has finished the packet |
| errFlag | output | 1 | Sticky: a boundary or length fault was seen |

## Verification
A busy phase that is wrongly kept or dropped shows up on the next poll read. That read returns the wrong status one cycle after it is issued, and `dmaReq` either rises when it should not or stays low. A fault in the address collapse appears on `dmaAddr` in the same cycle the request rises. The bench therefore compares the address for offsets that exercise every field and every ignored bit. Lost error state shows on `errFlag` straight away. A priority fault between completion and a new read shows on the same-cycle read.

// File: rtl/pollDmaPkg.sv
package pollDmaPkg;
  parameter int SYS_AW     = 23;
  parameter int OFF_W      = 20;
  parameter int LEN_W      = 13;
  parameter int DATA_W     = 32;
  parameter int MAX_LEN    = 4096;
  parameter int WIN_BITS   = 15;
  parameter int GAP_BITS   = 3;
  parameter int POLL_SHIFT = 9;
  parameter int ALIGN_BITS = 11;

  localparam int WIN_BYTES = 1 << WIN_BITS;
  localparam int SUM_W     = WIN_BITS + 2;

  typedef enum logic [1:0] {ENG_IDLE, ENG_REQ, ENG_RUN} engState_t;

  typedef struct packed {
    logic loadReq;   // latch address and length for a new fetch
    logic respBusy;  // the current read answers "refused"
    logic setErr;    // boundary or length fault seen
    logic respond;   // a read is being answered
  } ctrlStrobes_t;
endpackage

// File: rtl/pollDmaPath.sv
module pollDmaPath
  import pollDmaPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [OFF_W-1:0]    pollOff,
  input  logic [LEN_W-1:0]    pollLen,
  input  ctrlStrobes_t        strobes,
  input  logic                dmaReq,
  output logic                badReq,
  output logic [DATA_W-1:0]   rdData,
  output logic [SYS_AW-1:0]   dmaAddr,
  output logic [LEN_W-1:0]    dmaLen,
  output logic                errFlag
);
  localparam int LOW_FIELD_W  = WIN_BITS - ALIGN_BITS;
  localparam int HIGH_FIELD_W = SYS_AW - WIN_BITS;

  logic [SYS_AW-1:0] sysAddr;
  logic [SUM_W-1:0]  endPos;
  logic              crossWin;
  logic              tooLong;

  // Collapse the remap: undo the poll shift, then close the gap above the window.
  always_comb begin
    sysAddr = '0;
    sysAddr[WIN_BITS-1:ALIGN_BITS] =
      pollOff[WIN_BITS-POLL_SHIFT-1 -: LOW_FIELD_W];
    sysAddr[SYS_AW-1:WIN_BITS] =
      pollOff[WIN_BITS+GAP_BITS-POLL_SHIFT +: HIGH_FIELD_W];
  end

  assign endPos   = SUM_W'(sysAddr[WIN_BITS-1:0]) + SUM_W'(pollLen);
  assign crossWin = endPos > SUM_W'(WIN_BYTES);
  assign tooLong  = int'(pollLen) > MAX_LEN;
  assign badReq   = crossWin || tooLong;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      dmaAddr <= '0;
      dmaLen  <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strobes.respond) rdData <= DATA_W'(strobes.respBusy);
      if (strobes.loadReq) begin
        dmaAddr <= sysAddr;
        dmaLen  <= pollLen;
      end
      if (strobes.setErr) errFlag <= 1'b1;
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !strobes.loadReq) |=> ($stable(dmaAddr) && $stable(dmaLen))) else $error("request fields changed"); // R5

  AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> ((SUM_W'(dmaAddr[WIN_BITS-1:0]) + SUM_W'(dmaLen)) <= SUM_W'(WIN_BYTES)) && (int'(dmaLen) <= MAX_LEN)) else $error("illegal fetch issued"); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag) else $error("error flag dropped"); // R10

  AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rdData >> 1) == '0) else $error("status has stray bits"); // R2
endmodule

// File: rtl/pollDmaCtrl.sv
module pollDmaCtrl
  import pollDmaPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pollRd,
  input  logic         badReq,
  input  logic         dmaAck,
  input  logic         dmaDone,
  output ctrlStrobes_t strobes,
  output logic         rdValid,
  output logic         dmaReq
);
  engState_t state, stateNext;
  logic      engineFree;
  logic      accept;

  // A completion in the same cycle frees the engine before the read is judged.
  assign engineFree = (state == ENG_IDLE) || (state == ENG_RUN && dmaDone);
  assign accept     = pollRd && engineFree && !badReq;

  always_comb begin
    strobes.loadReq  = accept;
    strobes.respBusy = pollRd && !accept;
    strobes.setErr   = pollRd && badReq;
    strobes.respond  = pollRd;
  end

  always_comb begin
    stateNext = state;
    if (accept) stateNext = ENG_REQ;
    else begin
      unique case (state)
        ENG_REQ: if (dmaAck)  stateNext = ENG_RUN;
        ENG_RUN: if (dmaDone) stateNext = ENG_IDLE;
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ENG_IDLE;
      rdValid <= 1'b0;
    end else begin
      state   <= stateNext;
      rdValid <= pollRd;
    end
  end

  assign dmaReq = (state == ENG_REQ);

  AST_RD_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    pollRd |=> rdValid) else $error("read not answered"); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck) |=> dmaReq) else $error("request dropped early"); // R5

  AST_REQ_FROM_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> $past(pollRd)) else $error("request without read"); // R6

  AST_BUSY_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (pollRd && dmaReq) |=> !strobes.loadReq || state == ENG_REQ) else $error("launch while busy"); // R6

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    state != 2'b11) else $error("illegal state"); // R1
endmodule

// File: rtl/pollDmaLauncher.sv
module pollDmaLauncher
  import pollDmaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pollRd,
  input  logic [OFF_W-1:0]  pollOff,
  input  logic [LEN_W-1:0]  pollLen,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              dmaReq,
  output logic [SYS_AW-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  input  logic              dmaAck,
  input  logic              dmaDone,
  output logic              errFlag
);
  ctrlStrobes_t strobes;
  logic         badReq;

  pollDmaCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .pollRd(pollRd), .badReq(badReq),
    .dmaAck(dmaAck), .dmaDone(dmaDone), .strobes(strobes),
    .rdValid(rdValid), .dmaReq(dmaReq)
  );

  pollDmaPath i_path (
    .clk(clk), .rstN(rstN), .pollOff(pollOff), .pollLen(pollLen),
    .strobes(strobes), .dmaReq(dmaReq), .badReq(badReq), .rdData(rdData),
    .dmaAddr(dmaAddr), .dmaLen(dmaLen), .errFlag(errFlag)
  );
endmodule

// File: tb/test_pollDmaLauncher.sv
module test_pollDmaLauncher;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pollRd = 1'b0;
  logic [19:0] pollOff = '0;
  logic [12:0] pollLen = '0;
  logic        dmaAck = 1'b0;
  logic        dmaDone = 1'b0;
  logic        rdValid, dmaReq, errFlag;
  logic [31:0] rdData;
  logic [22:0] dmaAddr;
  logic [12:0] dmaLen;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pollDmaLauncher i_pollDmaLauncher (
    .clk(clk), .rstN(rstN), .pollRd(pollRd), .pollOff(pollOff),
    .pollLen(pollLen), .rdValid(rdValid), .rdData(rdData), .dmaReq(dmaReq),
    .dmaAddr(dmaAddr), .dmaLen(dmaLen), .dmaAck(dmaAck), .dmaDone(dmaDone),
    .errFlag(errFlag)
  );

  localparam int NV = 7;
  localparam logic [19:0] V_OFF [NV] = '{20'h00000, 20'h0003C, 20'h0003C, 20'h1FE00,
                                         20'hE01C3, 20'h00204, 20'h00214};
  localparam logic [12:0] V_LEN [NV] = '{13'd64, 13'd2048, 13'd2049, 13'd4096,
                                         13'd100, 13'd4097, 13'd4096};
  localparam logic        V_ST  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [22:0] V_ADR [NV] = '{23'h000000, 23'h007800, 23'h0, 23'h7F8000,
                                         23'h000000, 23'h0, 23'h00A800};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doPoll(input logic [19:0] off, input logic [12:0] len);
    @(negedge clk);
    pollOff = off; pollLen = len; pollRd = 1'b1;
    @(negedge clk);
    pollRd = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); dmaAck = 1'b1;
    @(negedge clk); dmaAck = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); dmaDone = 1'b1;
    @(negedge clk); dmaDone = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 dmaReq", 32'(dmaReq), 0);
    check("R1 rdValid", 32'(rdValid), 0);
    check("R1 errFlag", 32'(errFlag), 0);

    for (int i = 0; i < NV; i++) begin
      doPoll(V_OFF[i], V_LEN[i]);
      check("R2 rdValid", 32'(rdValid), 1);
      check("R2 status", rdData, 32'(V_ST[i]));
      if (!V_ST[i]) begin
        check("R3 R4 dmaAddr", 32'(dmaAddr), 32'(V_ADR[i]));
        check("R5 dmaLen", 32'(dmaLen), 32'(V_LEN[i]));
        check("R5 dmaReq", 32'(dmaReq), 1);
        pulseAck();
        check("R5 req drop", 32'(dmaReq), 0);
        pulseDone();
      end else begin
        check("R8 R9 no request", 32'(dmaReq), 0);
        check("R8 R9 errFlag", 32'(errFlag), 1);
      end
      @(negedge clk);
      check("R2 one-cycle valid", 32'(rdValid), 0);
    end
    check("R10 sticky after good reads", 32'(errFlag), 1);

    // Busy while the request waits for ack
    doPoll(20'h00004, 13'd256);
    check("R2 accept", rdData, 0);
    doPoll(20'h00200, 13'd16);
    check("R6 busy in request", rdData, 1);
    check("R5 addr held", 32'(dmaAddr), 32'h000800);
    check("R5 len held", 32'(dmaLen), 256);
    check("R5 req held", 32'(dmaReq), 1);
    pulseAck();
    doPoll(20'h00200, 13'd16);
    check("R6 busy in run", rdData, 1);
    check("R6 no new request", 32'(dmaReq), 0);

    // Completion and read in the same cycle
    @(negedge clk);
    pollOff = 20'h00200; pollLen = 13'd16; pollRd = 1'b1; dmaDone = 1'b1;
    @(negedge clk);
    pollRd = 1'b0; dmaDone = 1'b0;
    check("R7 status", rdData, 0);
    check("R7 new request", 32'(dmaReq), 1);
    check("R7 addr", 32'(dmaAddr), 32'h008000);
    pulseAck();
    pulseDone();

    // Reset clears the sticky flag
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R10 reset clears", 32'(errFlag), 0);
    check("R1 idle after reset", 32'(dmaReq), 0);
    doPoll(20'h0003C, 13'd2048);
    check("R1 first read accepted", rdData, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule